// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Status Flags

This block is a 16-bit two's-complement arithmetic-logic unit that registers both its result and a six-bit set of status flags. Each accepted operation takes an X and a Y operand and an opcode. The unit then produces a result, along with zero, negative, overflow, carry, sign and quotient flags. Add-with-carry takes its carry-in from the stored carry flag, so multi-word additions can be chained across successive operations.

The operation set has three groups. The arithmetic group is add, add with carry and subtract. The bitwise group is AND, OR, XOR and pass. The third group holds the special operations: absolute value, a signed divide step and an unsigned divide step. Each flag has its own update rule. The sign flag changes only on absolute value, and the quotient flag changes only on the two divide steps. All other operations leave those two flags as they were. Carry and overflow come from the shared adder: carry is the carry out of the top bit stage, and overflow is that carry XOR the carry out of the stage below it.

A controller presents the operands together with a one-cycle valid strobe. The registers load on the next clock edge. When valid is low, the registers keep their values.

Top module: `alu_status_unit`

## Requirements
- R1: The zero flag is 1 exactly when all result bits are 0, and this holds after every update and after reset.
- R2: The negative flag always equals the most significant bit of the result.
- R3: Opcode 0 (add) gives X+Y. Opcode 1 (add with carry) gives X+Y plus the stored carry flag. Opcode 2 (subtract) gives X+~Y+1. For these three, carry is the carry out of bit 15, which is 1 on subtract when there is no borrow. Overflow is the carry out of bit 15 XOR the carry out of bit 14.
- R4: Opcodes 3 (AND), 4 (OR), 5 (XOR) and 6 (pass X) produce the bitwise result, or X for pass, and clear both carry and overflow.
- R5: Opcode 7 (absolute value) returns |X|, clears carry, and loads the sign flag with bit 15 of X. No other operation changes the sign flag.
- R6: The absolute value of 0x8000 returns 0x8000 and sets overflow. For every other X, overflow is cleared.
- R7: Only opcodes 8 and 9 (the divide steps) write the quotient flag. Every other operation holds it.
- R8: Opcode 8 (signed divide step) returns X and sets quotient to the XNOR of bit 15 of X and bit 15 of Y. It clears carry and overflow.
- R9: Opcode 9 (unsigned divide step) performs the trial subtraction X-Y. Quotient is the inverted borrow, so it is 1 when X >= Y unsigned. The result is X-Y when quotient is 1, and X otherwise. Carry and overflow are cleared.
- R10: The result and the flags update on the first rising clock edge at which valid is high. When valid is low, or when the opcode is 10 to 15, the result and all flags hold.
- R11: Reset (active-low, asynchronous) sets the result to 0, the zero flag to 1 and all other flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Accept the operation this cycle |
| op_i | input | 4 | Opcode, encoded as in R3 to R10 |
| x_i | input | 16 | X operand |
| y_i | input | 16 | Y operand |
| result_o | output | 16 | Registered result |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |
| carry_o | output | 1 | Carry flag |
| sign_o | output | 1 | Sign flag (absolute value only) |
| quot_o | output | 1 | Quotient flag (divide steps only) |

## Verification
The bench builds the unit at its default width of 16 bits. At that width the edge operands can be written exactly: 0x7FFF and 0x8000 for signed overflow in both directions, 0xFFFF+1 for carry combined with a zero result, and 0x8000 for absolute-value overflow. A carry-chained add, back-to-back divide steps, idle cycles and unused opcodes confirm which flags are held and which are written. A long stream of random operations mixed with edge values then exercises every opcode against the flag state left by the operation before it.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_PASS = 4'd6,
    OP_ABS  = 4'd7,
    OP_DIVS = 4'd8,
    OP_DIVQ = 4'd9
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
    logic s;
    logic q;
  } alu_flags_t;

  localparam alu_flags_t FLAGS_RST = '{z: 1'b1, default: 1'b0};

  function automatic logic op_is_logic(alu_op_e op);
    return op inside {OP_AND, OP_OR, OP_XOR, OP_PASS};
  endfunction

  function automatic logic op_is_div(alu_op_e op);
    return op inside {OP_DIVS, OP_DIVQ};
  endfunction
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,  // carry out of top stage
  output logic         cpen_o   // carry out of stage W-2 (into top stage)
);
  logic [W:0] full;

  assign full   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
  assign sum_o  = full[W-1:0];
  assign cout_o = full[W];
  // carry into top stage recovered from its sum bit
  assign cpen_o = a_i[W-1] ^ b_i[W-1] ^ full[W-1];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit import alu_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i;
    endcase
  end
endmodule

// File: rtl/alu_flag_next.sv
module alu_flag_next import alu_pkg::*; #(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] res_i,
  input  logic         x_msb_i,
  input  logic         cout_i,
  input  logic         cpen_i,
  input  logic         q_new_i,
  input  alu_flags_t   flags_q_i,
  output alu_flags_t   flags_d_o
);
  logic res_zero;
  assign res_zero = ~|res_i;

  always_comb begin
    flags_d_o = flags_q_i;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB: begin
        flags_d_o.z = res_zero;
        flags_d_o.n = res_i[W-1];
        flags_d_o.c = cout_i;
        flags_d_o.v = cout_i ^ cpen_i;
      end
      OP_AND, OP_OR, OP_XOR, OP_PASS: begin
        flags_d_o.z = res_zero;
        flags_d_o.n = res_i[W-1];
        flags_d_o.c = 1'b0;
        flags_d_o.v = 1'b0;
      end
      OP_ABS: begin
        flags_d_o.z = res_zero;
        flags_d_o.n = res_i[W-1];
        flags_d_o.c = 1'b0;
        flags_d_o.v = x_msb_i & (cout_i ^ cpen_i);  // only min value overflows
        flags_d_o.s = x_msb_i;
      end
      OP_DIVS, OP_DIVQ: begin
        flags_d_o.z = res_zero;
        flags_d_o.n = res_i[W-1];
        flags_d_o.c = 1'b0;
        flags_d_o.v = 1'b0;
        flags_d_o.q = q_new_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit import alu_pkg::*; #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              ovf_o,
  output logic              carry_o,
  output logic              sign_o,
  output logic              quot_o
);
  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  alu_flags_t        flags_q, flags_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic [DATA_W-1:0] add_a, add_b, add_sum, logic_res;
  logic              add_c, add_cout, add_cpen, q_new;

  assign op = alu_op_e'(op_i);

  // shared adder operand select
  always_comb begin
    add_a = x_i;
    add_b = y_i;
    add_c = 1'b0;
    case (op)
      OP_ADC: add_c = flags_q.c;
      OP_SUB, OP_DIVQ: begin
        add_b = ~y_i;
        add_c = 1'b1;
      end
      OP_ABS: begin
        add_a = '0;
        add_b = ~x_i;
        add_c = 1'b1;
      end
      default: ;
    endcase
  end

  alu_adder #(.W(DATA_W)) u_adder (
    .a_i    (add_a),
    .b_i    (add_b),
    .c_i    (add_c),
    .sum_o  (add_sum),
    .cout_o (add_cout),
    .cpen_o (add_cpen)
  );

  alu_logic_unit #(.W(DATA_W)) u_logic (
    .op_i  (op),
    .a_i   (x_i),
    .b_i   (y_i),
    .res_o (logic_res)
  );

  assign q_new = (op == OP_DIVS) ? ~(x_i[MSB] ^ y_i[MSB]) : add_cout;

  always_comb begin
    case (op)
      OP_ADD, OP_ADC, OP_SUB:         res_d = add_sum;
      OP_AND, OP_OR, OP_XOR, OP_PASS: res_d = logic_res;
      OP_ABS:                         res_d = x_i[MSB] ? add_sum : x_i;
      OP_DIVS:                        res_d = x_i;
      OP_DIVQ:                        res_d = add_cout ? add_sum : x_i;
      default:                        res_d = res_q;
    endcase
  end

  alu_flag_next #(.W(DATA_W)) u_flags (
    .op_i      (op),
    .res_i     (res_d),
    .x_msb_i   (x_i[MSB]),
    .cout_i    (add_cout),
    .cpen_i    (add_cpen),
    .q_new_i   (q_new),
    .flags_q_i (flags_q),
    .flags_d_o (flags_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= FLAGS_RST;
    end else if (valid_i) begin
      res_q   <= res_d;
      flags_q <= flags_d;
    end
  end

  assign result_o = res_q;
  assign zero_o   = flags_q.z;
  assign neg_o    = flags_q.n;
  assign ovf_o    = flags_q.v;
  assign carry_o  = flags_q.c;
  assign sign_o   = flags_q.s;
  assign quot_o   = flags_q.q;
endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk import alu_pkg::*; #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] x_i,
  input logic [DATA_W-1:0] y_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o,
  input logic              neg_o,
  input logic              ovf_o,
  input logic              carry_o,
  input logic              sign_o,
  input logic              quot_o
);
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  logic acc_abs, acc_div, acc_logic, y_seen;
  assign acc_abs   = valid_i && (op_i == OP_ABS);
  assign acc_div   = valid_i && ((op_i == OP_DIVS) || (op_i == OP_DIVQ));
  assign acc_logic = valid_i && (op_i inside {OP_AND, OP_OR, OP_XOR, OP_PASS});
  assign y_seen    = ^y_i;

  assert_zero_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o == (result_o == '0));

  assert_neg_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    neg_o == result_o[DATA_W-1]);

  assert_logic_clear_cv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_logic |=> (!carry_o && !ovf_o));

  assert_abs_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_abs |=> sign_o == $past(x_i[DATA_W-1]));

  assert_sign_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_abs |=> $stable(sign_o));

  assert_abs_min_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_abs && x_i == MIN_NEG) |=> (result_o == MIN_NEG && ovf_o));

  assert_quot_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_div |=> $stable(quot_o));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || y_seen != y_seen) |=> ($stable(result_o) && $stable(zero_o) &&
      $stable(neg_o) && $stable(ovf_o) && $stable(carry_o)));
endmodule

bind alu_status_unit alu_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .x_i      (x_i),
  .y_i      (y_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .neg_o    (neg_o),
  .ovf_o    (ovf_o),
  .carry_o  (carry_o),
  .sign_o   (sign_o),
  .quot_o   (quot_o)
);

// File: tb/tb_alu_status_unit.sv
`timescale 1ns/1ps
module tb_alu_status_unit;
  typedef struct {
    logic [15:0] r;
    logic [5:0]  f;  // {z,n,v,c,s,q}
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = 4'd0;
  logic [15:0] x = '0, y = '0;
  logic [15:0] result;
  logic        zf, nf, vf, cf, sf, qf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  exp_t sb[$];
  exp_t got;

  logic [15:0] m_r = '0;
  logic m_z = 1'b1, m_n = 1'b0, m_v = 1'b0, m_c = 1'b0, m_s = 1'b0, m_q = 1'b0;

  always #2.5 clk = ~clk;

  alu_status_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .x_i(x), .y_i(y),
    .result_o(result), .zero_o(zf), .neg_o(nf), .ovf_o(vf), .carry_o(cf),
    .sign_o(sf), .quot_o(qf)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(logic [3:0] o, logic [15:0] a, logic [15:0] b);
    logic [16:0] s;
    logic [15:0] r;
    logic cy, ov, known;
    known = 1'b1; cy = 1'b0; ov = 1'b0; r = '0;
    case (o)
      4'd0, 4'd1: begin
        s = {1'b0, a} + {1'b0, b} + ((o == 4'd1) ? {16'd0, m_c} : 17'd0);
        r = s[15:0]; cy = s[16];
        ov = (a[15] == b[15]) && (r[15] != a[15]);
      end
      4'd2: begin
        s = {1'b0, a} + {1'b0, ~b} + 17'd1;
        r = s[15:0]; cy = s[16];
        ov = (a[15] != b[15]) && (r[15] != a[15]);
      end
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: r = a;
      4'd7: begin
        r = a[15] ? (~a + 16'd1) : a;
        ov = (a == 16'h8000);
        m_s = a[15];
      end
      4'd8: begin
        r = a;
        m_q = (a[15] == b[15]);
      end
      4'd9: begin
        m_q = (a >= b);
        r = (a >= b) ? a - b : a;
      end
      default: known = 1'b0;
    endcase
    if (known) begin
      m_r = r; m_z = (r == 16'd0); m_n = r[15]; m_c = cy; m_v = ov;
    end
  endtask

  task automatic drive(logic v, logic [3:0] o, logic [15:0] a, logic [15:0] b, string tag);
    exp_t e;
    @(negedge clk);
    valid = v; op = o; x = a; y = b;
    if (v) model(o, a, b);
    e.r = m_r; e.f = {m_z, m_n, m_v, m_c, m_s, m_q}; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: compare one cycle after each driven cycle
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      #1;
      got = sb.pop_front();
      check({got.tag, " result"}, result, got.r);
      check({got.tag, " flags"}, {10'd0, zf, nf, vf, cf, sf, qf}, {10'd0, got.f});
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset result", result, 16'd0);
    check("R11 reset flags", {10'd0, zf, nf, vf, cf, sf, qf}, 16'b10_0000);

    drive(1, 4'd0, 16'h1234, 16'h0001, "R3 add");
    drive(1, 4'd0, 16'h7FFF, 16'h0001, "R3 add overflow R2");
    drive(1, 4'd0, 16'hFFFF, 16'h0001, "R3 add carry R1 zero");
    drive(1, 4'd1, 16'h0001, 16'h0001, "R3 adc with carry");
    drive(1, 4'd1, 16'h0001, 16'h0001, "R3 adc no carry");
    drive(1, 4'd2, 16'h0005, 16'h0003, "R3 sub");
    drive(1, 4'd2, 16'h0003, 16'h0005, "R3 sub borrow R2");
    drive(1, 4'd2, 16'h8000, 16'h0001, "R3 sub overflow");
    drive(1, 4'd3, 16'hF0F0, 16'h0FF0, "R4 and");
    drive(1, 4'd0, 16'h7FFF, 16'h7FFF, "R3 set v");
    drive(1, 4'd4, 16'hF000, 16'h000F, "R4 or");
    drive(1, 4'd0, 16'hFFFF, 16'hFFFF, "R3 set c");
    drive(1, 4'd5, 16'hAAAA, 16'hAAAA, "R4 xor R1");
    drive(1, 4'd6, 16'h8001, 16'h0000, "R4 pass");
    drive(1, 4'd7, 16'hFFF0, 16'h0000, "R5 abs negative");
    drive(1, 4'd0, 16'h0001, 16'h0002, "R5 sign held");
    drive(1, 4'd7, 16'h8000, 16'h0000, "R6 abs min");
    drive(1, 4'd7, 16'h0005, 16'h0000, "R5 R6 abs positive");
    drive(1, 4'd8, 16'h8000, 16'h8000, "R8 divs same sign");
    drive(1, 4'd0, 16'h0001, 16'h0001, "R7 quot held");
    drive(1, 4'd8, 16'h8000, 16'h0001, "R8 divs diff sign");
    drive(1, 4'd9, 16'h0009, 16'h0004, "R9 divq take");
    drive(1, 4'd9, 16'h0003, 16'h0004, "R9 divq keep");
    drive(1, 4'd9, 16'h0004, 16'h0004, "R9 divq equal");
    drive(0, 4'd0, 16'h1111, 16'h2222, "R10 idle");
    drive(0, 4'd7, 16'h8000, 16'h0000, "R10 idle abs");
    drive(1, 4'd12, 16'hFFFF, 16'hFFFF, "R10 unused opcode");
    drive(1, 4'd15, 16'h0000, 16'h0000, "R10 unused opcode");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      case ($urandom_range(0, 3))
        0: a = 16'h8000;
        1: a = 16'h7FFF;
        default: a = 16'($urandom);
      endcase
      b = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom);
      drive(($urandom_range(0, 4) != 0), 4'($urandom_range(0, 11)), a, b,
            "R1 R2 R3 R4 R5 R7 R10 random");
    end

    @(negedge clk);
    valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule